// File: doc/BRIEF.md
# E3 Trail Trace Transmit Sequencer

This block stores a sixteen-byte path identification message and hands one byte of it to the E3 transmit framer per outgoing frame. The framer places that byte in the frame's trail trace overhead byte. Sixteen consecutive frames carry the whole message and make up one trace super-frame. Software loads the bytes through a write port that takes a 4-bit entry index and an 8-bit value. The framer pulses `frame_start` once per frame and samples `trace_byte`.

Entry 0 opens each super-frame. Its most significant bit is 1, which marks the start byte. Its low seven bits hold a CRC-7 that software computes over the sixteen bytes of the previous super-frame. The block sends that byte exactly as written and computes no CRC of its own. Entries 1 to 15 hold the identifier characters and have a most significant bit of 0. When software writes a byte whose marker bit does not match its position, the block raises a sticky `marker_fault` flag. Software clears the flag with a one-cycle pulse on `fault_clear`.

The reset input is asynchronous and active-low. Its release is synchronised inside the block, so the block starts to act on its inputs on the third rising edge after `rst_n` goes high.

Top module: `ttb_tx_seq`

## Requirements
- R1: While reset is applied, and after it until the first strobe, `trace_byte` = 0x00, `cur_entry` = 0, `sf_first` = 0 and `marker_fault` = 0. Every entry is cleared to 0x00.
- R2: On a rising edge with `cfg_we` high, `cfg_data` is stored in the entry selected by `cfg_idx`. The stored value is seen on `trace_byte` the next time that entry is sent.
- R3: On each `frame_start` edge, `trace_byte` and `cur_entry` take the next entry and its index. The index rises by one per strobe and wraps from 15 back to 0.
- R4: The first strobe after reset sends entry 0. `sf_first` is 1 exactly while the frame being sent carries entry 0.
- R5: Between strobes, `trace_byte`, `cur_entry` and `sf_first` do not change. A write to an entry, including one on the same edge as the strobe that selects it, reaches `trace_byte` no earlier than the next time that entry is selected.
- R6: Entry 0 is sent bit for bit as written, with no CRC inserted or altered by the block.
- R7: `marker_fault` goes to 1 on the edge of a write of entry 0 with bit 7 = 0, and on the edge of a write of entries 1 to 15 with bit 7 = 1.
- R8: A `fault_clear` pulse clears `marker_fault` on that edge. If a faulty write happens on the same edge, the flag stays set. Otherwise the flag holds its value.
- R9: While `cfg_we` is low, `cfg_idx` and `cfg_data` change no entry and do not affect `marker_fault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Entry write enable |
| cfg_idx | input | 4 | Entry index to write |
| cfg_data | input | 8 | Entry value to write |
| fault_clear | input | 1 | Clear pulse for `marker_fault` |
| frame_start | input | 1 | One-cycle strobe per outgoing frame |
| trace_byte | output | 8 | Trail trace byte for the current frame |
| cur_entry | output | 4 | Index of the entry being sent |
| sf_first | output | 1 | High while the current frame carries entry 0 |
| marker_fault | output | 1 | Sticky marker-bit violation flag |

## Verification
The assertions check several rules on every cycle:
- each strobe moves `cur_entry` to the next index, with the wrap from 15 to 0;
- the first strobe after reset lands on entry 0;
- `sf_first` agrees with the index;
- the outputs hold between strobes;
- the fault flag is set, cleared and held as R7 and R8 require.

Whether the byte sent is the value stored at that index cannot be seen from the ports in a single cycle. That needs the bench's scenarios. They show the cleared contents after reset, verbatim delivery of entry 0, a write that lands on the same edge as the strobe that reads it, and writes made with the enable low.

// File: rtl/ttb_pkg.sv
package ttb_pkg;
  localparam int TTB_ENTRIES = 16;
  localparam int TTB_WIDTH   = 8;

  // Marker rule: only entry 0 may carry the top bit set.
  function automatic logic marker_bad(input logic is_first, input logic msb);
    return is_first ? ~msb : msb;
  endfunction
endpackage

// File: rtl/ttb_regfile.sv
module ttb_regfile #(
  parameter int ENTRIES = ttb_pkg::TTB_ENTRIES,
  parameter int DW      = ttb_pkg::TTB_WIDTH,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] rows [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic          row_en;
    logic [DW-1:0] row_q;
    logic [DW-1:0] row_d;

    assign row_en = wr_en && (wr_idx == IW'(e));
    assign row_d  = row_en ? wr_data : row_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) row_q <= '0;
      else        row_q <= row_d;
    end

    assign rows[e] = row_q;
  end

  assign rd_data = rows[rd_idx];
endmodule

// File: rtl/ttb_rotator.sv
module ttb_rotator #(
  parameter int ENTRIES = ttb_pkg::TTB_ENTRIES,
  parameter int DW      = ttb_pkg::TTB_WIDTH,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  output logic [IW-1:0] sel_idx,
  input  logic [DW-1:0] sel_data,
  output logic [DW-1:0] out_byte,
  output logic [IW-1:0] out_idx,
  output logic          out_first
);
  localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

  logic [IW-1:0] ptr_q, ptr_d;
  logic [DW-1:0] byte_q, byte_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          first_q, first_d;

  always_comb begin
    ptr_d   = ptr_q;
    byte_d  = byte_q;
    idx_d   = idx_q;
    first_d = first_q;
    if (frame_start) begin
      byte_d  = sel_data;
      idx_d   = ptr_q;
      first_d = (ptr_q == '0);
      ptr_d   = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      byte_q  <= '0;
      idx_q   <= '0;
      first_q <= 1'b0;
    end else begin
      ptr_q   <= ptr_d;
      byte_q  <= byte_d;
      idx_q   <= idx_d;
      first_q <= first_d;
    end
  end

  assign sel_idx   = ptr_q;
  assign out_byte  = byte_q;
  assign out_idx   = idx_q;
  assign out_first = first_q;
endmodule

// File: rtl/ttb_marker_mon.sv
module ttb_marker_mon #(
  parameter int ENTRIES = ttb_pkg::TTB_ENTRIES,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic          wr_msb,
  input  logic          clear,
  output logic          fault
);
  logic fault_q, fault_d;
  logic bad_wr;

  assign bad_wr = wr_en && ttb_pkg::marker_bad(wr_idx == '0, wr_msb);

  always_comb begin
    fault_d = fault_q;
    if (bad_wr)     fault_d = 1'b1;
    else if (clear) fault_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_q <= 1'b0;
    else        fault_q <= fault_d;
  end

  assign fault = fault_q;
endmodule

// File: rtl/ttb_tx_seq.sv
module ttb_tx_seq #(
  parameter int ENTRIES = ttb_pkg::TTB_ENTRIES,
  parameter int DW      = ttb_pkg::TTB_WIDTH,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_idx,
  input  logic [DW-1:0] cfg_data,
  input  logic          fault_clear,
  input  logic          frame_start,
  output logic [DW-1:0] trace_byte,
  output logic [IW-1:0] cur_entry,
  output logic          sf_first,
  output logic          marker_fault
);
  // Reset asserts at once and releases on a clock edge.
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [IW-1:0] sel_idx;
  logic [DW-1:0] sel_data;

  ttb_regfile #(.ENTRIES(ENTRIES), .DW(DW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (cfg_we),
    .wr_idx  (cfg_idx),
    .wr_data (cfg_data),
    .rd_idx  (sel_idx),
    .rd_data (sel_data)
  );

  ttb_rotator #(.ENTRIES(ENTRIES), .DW(DW)) u_rot (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .frame_start (frame_start),
    .sel_idx     (sel_idx),
    .sel_data    (sel_data),
    .out_byte    (trace_byte),
    .out_idx     (cur_entry),
    .out_first   (sf_first)
  );

  ttb_marker_mon #(.ENTRIES(ENTRIES)) u_mon (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (cfg_we),
    .wr_idx (cfg_idx),
    .wr_msb (cfg_data[DW-1]),
    .clear  (fault_clear),
    .fault  (marker_fault)
  );
endmodule

// File: rtl/ttb_tx_seq_chk.sv
module ttb_tx_seq_chk #(
  parameter int ENTRIES = ttb_pkg::TTB_ENTRIES,
  parameter int DW      = ttb_pkg::TTB_WIDTH,
  localparam int IW     = $clog2(ENTRIES)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [IW-1:0] cfg_idx,
  input logic [DW-1:0] cfg_data,
  input logic          fault_clear,
  input logic          frame_start,
  input logic [DW-1:0] trace_byte,
  input logic [IW-1:0] cur_entry,
  input logic          sf_first,
  input logic          marker_fault
);
  logic started_q;
  logic bad_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           started_q <= 1'b0;
    else if (frame_start) started_q <= 1'b1;
  end

  assign bad_wr = cfg_we && ((cfg_idx == '0) ? !cfg_data[DW-1] : cfg_data[DW-1]);

  function automatic logic [IW-1:0] succ(input logic [IW-1:0] i);
    return (i == IW'(ENTRIES - 1)) ? '0 : i + 1'b1;
  endfunction

  assert_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    started_q && frame_start |=> cur_entry == succ($past(cur_entry)));

  assert_first_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !started_q && frame_start |=> cur_entry == '0 && sf_first);

  assert_sf_matches_R4: assert property (@(posedge clk) disable iff (!rst_n)
    started_q |-> (sf_first == (cur_entry == '0)));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(trace_byte) && $stable(cur_entry) && $stable(sf_first));

  assert_fault_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bad_wr |=> marker_fault);

  assert_fault_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_clear && !bad_wr |=> !marker_fault);

  assert_fault_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_clear && !bad_wr |=> $stable(marker_fault));
endmodule

bind ttb_tx_seq ttb_tx_seq_chk #(.ENTRIES(ENTRIES), .DW(DW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .cfg_we       (cfg_we),
  .cfg_idx      (cfg_idx),
  .cfg_data     (cfg_data),
  .fault_clear  (fault_clear),
  .frame_start  (frame_start),
  .trace_byte   (trace_byte),
  .cur_entry    (cur_entry),
  .sf_first     (sf_first),
  .marker_fault (marker_fault)
);

// File: tb/ttb_tx_seq_test.sv
module ttb_tx_seq_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we, fault_clear, frame_start;
  logic [3:0] cfg_idx;
  logic [7:0] cfg_data;
  logic [7:0] trace_byte;
  logic [3:0] cur_entry;
  logic       sf_first, marker_fault;

  always #5 clk = ~clk;

  ttb_tx_seq uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_data(cfg_data), .fault_clear(fault_clear), .frame_start(frame_start),
    .trace_byte(trace_byte), .cur_entry(cur_entry), .sf_first(sf_first),
    .marker_fault(marker_fault)
  );

  // Reference model
  int  mem [16];
  int  ptr, e_byte, e_idx;
  bit  e_first, e_fault;
  int  total = 0, bad = 0;
  bit  done = 0;

  task automatic check(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    check(tag, "trace_byte", int'(trace_byte), e_byte);
    check(tag, "cur_entry", int'(cur_entry), e_idx);
    check(tag, "sf_first", int'(sf_first), int'(e_first));
    check(tag, "marker_fault", int'(marker_fault), int'(e_fault));
  endtask

  // Drive one cycle (from a negedge), update the model at the edge, compare at the next negedge.
  task automatic step(string tag, bit we, int idx, int data, bit sof, bit clr);
    bit badw;
    cfg_we = we; cfg_idx = 4'(idx); cfg_data = 8'(data);
    frame_start = sof; fault_clear = clr;
    @(posedge clk);
    if (sof) begin
      e_byte = mem[ptr]; e_idx = ptr; e_first = (ptr == 0);
      ptr = (ptr + 1) % 16;
    end
    badw = we && ((idx == 0) ? (data < 128) : (data >= 128));
    if (we) mem[idx] = data & 255;
    if (badw) e_fault = 1;
    else if (clr) e_fault = 0;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic model_reset();
    foreach (mem[i]) mem[i] = 0;
    ptr = 0; e_byte = 0; e_idx = 0; e_first = 0; e_fault = 0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cfg_we = 0; cfg_idx = 0; cfg_data = 0; fault_clear = 0; frame_start = 0;
    rst_n = 0;
    model_reset();
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1;
    for (int i = 0; i < 3; i++) step("R1", 0, 0, 0, 0, 0);
    // R1: all entries cleared, R4 first frame entry 0
    for (int i = 0; i < 16; i++) step("R1", 0, 0, 0, 1, 0);
    // R2: load a proper message, entry 0 with marker and a CRC field
    step("R2", 1, 0, 8'hA5, 0, 0);
    for (int i = 1; i < 16; i++) step("R2", 1, i, 8'h30 + i, 0, 0);
    // R3/R4/R6: rotate across more than two super-frames with gaps
    for (int i = 0; i < 40; i++) begin
      step("R3", 0, 0, 0, 1, 0);
      if (i % 3 == 0) step("R5", 0, 0, 0, 0, 0);
    end
    // Now next pointer is 8. Write entry 8 on the same edge as its strobe (R5)
    step("R5", 1, 8, 8'h55, 1, 0);
    for (int i = 0; i < 15; i++) step("R5", 0, 0, 0, 1, 0);
    step("R5", 0, 0, 0, 1, 0);   // entry 8 again, now new value
    // R6: entry 0 rewritten with a different CRC field, seen verbatim
    step("R6", 1, 0, 8'hFF, 0, 0);
    for (int i = 0; i < 8; i++) step("R6", 0, 0, 0, 1, 0);
    // R9: disabled writes, one with a bad marker
    step("R9", 0, 9, 8'hEE, 0, 0);
    step("R9", 0, 0, 8'h01, 0, 0);
    for (int i = 0; i < 16; i++) step("R9", 0, 0, 0, 1, 0);
    // R7/R8: marker faults and clearing
    step("R7", 1, 3, 8'h80, 0, 0);
    step("R8", 0, 0, 0, 0, 0);
    step("R8", 0, 0, 0, 0, 1);
    step("R7", 1, 0, 8'h15, 0, 0);
    step("R8", 1, 7, 8'hC1, 0, 1);
    step("R8", 0, 0, 0, 0, 1);
    step("R8", 1, 0, 8'h80, 0, 0);
    step("R7", 1, 15, 8'h41, 1, 0);
    for (int i = 0; i < 16; i++) step("R3", 0, 0, 0, 1, 0);
    // R1: reset mid-run clears contents and alignment
    rst_n = 0;
    model_reset();
    @(negedge clk);
    compare("R1");
    rst_n = 1;
    for (int i = 0; i < 3; i++) step("R1", 0, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) step("R4", 0, 0, 0, 1, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule